// File: doc/BRIEF.md
# Parallel Configuration Byte Streamer

This block loads a programmable device through its byte-wide parallel configuration port. On a start request it clears the device by holding an active-low program line low for a set number of clock cycles. It then waits, with a timeout, for the device's active-low init line to read high. After that it writes a fixed eight-byte header. The bitstream arrives from a valid/ready byte source and goes out in frames of 21 payload bytes. Each frame has a preamble byte in front of it and a check byte plus five extended-write filler bytes behind it. The block ends with four startup bytes.

Between frames the block looks at the synchronised init and done pins. It opens a new frame only while init is high, done is low and payload is still outstanding. A source that runs dry part-way through a frame has the rest of that frame filled with 0xFF. The result is reported on two sticky flags that hold until the next start. The block never stores the bitstream; it only paces it.

Top module: `cfg_byte_streamer`

## Requirements
- R1: A start pulse while idle drives `prog_n_o` low for exactly PROG_LOW_CYCLES cycles, then high. No write strobe and no `src_ready_o` occur while it is low.
- R2: No byte is written before `init_n_i` has been seen high. If init stays low for INIT_TIMEOUT_CYCLES cycles after program is released, the block returns to idle with `err_o` set and no byte written.
- R3: The first eight writes are 0xFF, 0xFF, 0xFF, 0x4F, 0x80, 0xAF, 0x9B, 0x4B, in that order.
- R4: Every frame is 28 writes: 0x4F, then 21 payload bytes in source order, then 0x4B, 0xFF, 0x4B, 0xFF, 0xFF, 0xFF.
- R5: At the boundary after the header and after each frame, a new frame starts only if init is high, done is low and the source has not yet delivered the byte flagged by `src_last_i`. Otherwise no further frame is written.
- R6: If the source's last byte falls inside a frame, the remaining payload positions of that frame are written as 0xFF.
- R7: After the final frame, or when framing stops, exactly four 0xFF startup bytes are written, and the block then leaves busy.
- R8: At the end `ok_o` is set only if the last payload byte was taken and done reads high. Otherwise `err_o` is set. The two are never high together, and both clear on the next start.
- R9: Two write strobes are always at least SPACING clock cycles apart.
- R10: `src_ready_o` is high only in a payload slot of a frame before the last byte has been taken. Each accepted byte is written exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load (taken while idle) |
| src_valid_i | input | 1 | Source byte available |
| src_data_i | input | 8 | Source byte |
| src_last_i | input | 1 | Marks the final source byte |
| src_ready_o | output | 1 | Block takes the source byte this cycle |
| cfg_wr_o | output | 1 | Write strobe to the configuration port |
| cfg_data_o | output | 8 | Byte written to the configuration port |
| prog_n_o | output | 1 | Active-low program line |
| init_n_i | input | 1 | Active-low init line from device |
| done_i | input | 1 | Done line from device |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load completed correctly |
| err_o | output | 1 | Last load failed or timed out |

## Verification
A slip in the byte index shows up in the written stream within the same frame. The header or trailer then comes out at a wrong position, and the first mismatching byte identifies the segment. A wrong boundary decision changes the total write count and the number of source bytes taken, and it is visible by the end of the run. A wrong result latch, pacing count or program timer shows at the ports within one load, as a wrong flag, a gap shorter than SPACING or a pulse of the wrong length.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PROG, ST_WAIT, ST_HDR, ST_CHK,
    ST_PRE, ST_PAY, ST_TAIL, ST_BOOT, ST_END
  } cbs_state_e;

  localparam logic [7:0] BYTE_PREAMBLE = 8'h4F;
  localparam logic [7:0] BYTE_CHECK    = 8'h4B;
  localparam logic [7:0] BYTE_FILL     = 8'hFF;
  localparam int         HDR_LEN       = 8;
  localparam int         TAIL_LEN      = 6;
  localparam int         BOOT_LEN      = 4;

  // Fixed lead-in written once before the first frame.
  function automatic logic [7:0] hdr_byte(input logic [2:0] pos);
    case (pos)
      3'd3:    return BYTE_PREAMBLE;
      3'd4:    return 8'h80;
      3'd5:    return 8'hAF;
      3'd6:    return 8'h9B;
      3'd7:    return BYTE_CHECK;
      default: return BYTE_FILL;
    endcase
  endfunction

  // Trailer after the payload of a frame: check, then extended-write fill.
  function automatic logic [7:0] tail_byte(input logic [2:0] pos);
    case (pos)
      3'd0, 3'd2: return BYTE_CHECK;
      default:    return BYTE_FILL;
    endcase
  endfunction

endpackage

// File: rtl/cbs_sync.sv
module cbs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int CW = W * STAGES;
  logic [CW-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[CW-W-1:0], d_i};
  end

  assign q_o = chain[CW-1 -: W];
endmodule

// File: rtl/cbs_timer.sv
module cbs_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load_i)      cnt <= load_val_i;
    else if (cnt != '0)   cnt <= cnt - TW'(1);
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/cbs_pace.sv
module cbs_pace #(
  parameter int SPACING = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  output logic slot_o
);
  localparam int CW = (SPACING < 2) ? 1 : $clog2(SPACING);
  localparam logic [CW-1:0] RELOAD = CW'(SPACING - 1);
  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wait_cnt <= '0;
    else if (stb_i)          wait_cnt <= RELOAD;
    else if (wait_cnt != '0) wait_cnt <= wait_cnt - CW'(1);
  end

  assign slot_o = (wait_cnt == '0);
endmodule

// File: rtl/cbs_seq.sv
module cbs_seq
  import cbs_pkg::*;
#(
  parameter int FRAME_BYTES = 21,
  parameter int TW          = 16,
  parameter logic [TW-1:0] PROG_LOAD = '0,
  parameter logic [TW-1:0] WAIT_LOAD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          src_valid_i,
  input  logic [7:0]    src_data_i,
  input  logic          src_last_i,
  output logic          src_ready_o,
  input  logic          slot_i,
  input  logic          init_hi_i,
  input  logic          done_hi_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          emit_o,
  output logic [7:0]    emit_byte_o,
  output logic          frame_go_o,
  output logic          timeout_o,
  output logic          finish_o,
  output cbs_state_e    state_o,
  output logic          ok_o,
  output logic          err_o
);
  localparam int IMAX = (FRAME_BYTES > HDR_LEN) ? FRAME_BYTES : HDR_LEN;
  localparam int IW   = $clog2(IMAX);
  localparam logic [IW-1:0] PAY_END  = IW'(FRAME_BYTES - 1);
  localparam logic [IW-1:0] HDR_END  = IW'(HDR_LEN - 1);
  localparam logic [IW-1:0] TAIL_END = IW'(TAIL_LEN - 1);
  localparam logic [IW-1:0] BOOT_END = IW'(BOOT_LEN - 1);

  cbs_state_e    st, st_n;
  logic [IW-1:0] idx, idx_n;
  logic          last_q;
  logic          take;

  assign src_ready_o = (st == ST_PAY) && slot_i && !last_q;

  always_comb begin
    st_n        = st;
    idx_n       = idx;
    emit_o      = 1'b0;
    emit_byte_o = BYTE_FILL;
    take        = 1'b0;
    tmr_load_o  = 1'b0;
    tmr_val_o   = PROG_LOAD;
    frame_go_o  = 1'b0;
    timeout_o   = 1'b0;
    finish_o    = 1'b0;
    case (st)
      ST_IDLE: begin
        if (start_i) begin
          st_n       = ST_PROG;
          tmr_load_o = 1'b1;
        end
      end
      ST_PROG: begin
        if (tmr_zero_i) begin
          st_n       = ST_WAIT;
          tmr_load_o = 1'b1;
          tmr_val_o  = WAIT_LOAD;
        end
      end
      ST_WAIT: begin
        if (init_hi_i) begin
          st_n  = ST_HDR;
          idx_n = '0;
        end else if (tmr_zero_i) begin
          timeout_o = 1'b1;
          st_n      = ST_IDLE;
        end
      end
      ST_HDR: begin
        if (slot_i) begin
          emit_o      = 1'b1;
          emit_byte_o = hdr_byte(idx[2:0]);
          if (idx == HDR_END) begin
            st_n  = ST_CHK;
            idx_n = '0;
          end else begin
            idx_n = idx + IW'(1);
          end
        end
      end
      ST_CHK: begin
        idx_n = '0;
        if (init_hi_i && !done_hi_i && !last_q) begin
          frame_go_o = 1'b1;
          st_n       = ST_PRE;
        end else begin
          st_n = ST_BOOT;
        end
      end
      ST_PRE: begin
        if (slot_i) begin
          emit_o      = 1'b1;
          emit_byte_o = BYTE_PREAMBLE;
          st_n        = ST_PAY;
          idx_n       = '0;
        end
      end
      ST_PAY: begin
        if (slot_i && (last_q || src_valid_i)) begin
          emit_o      = 1'b1;
          take        = !last_q;
          emit_byte_o = last_q ? BYTE_FILL : src_data_i;
          if (idx == PAY_END) begin
            st_n  = ST_TAIL;
            idx_n = '0;
          end else begin
            idx_n = idx + IW'(1);
          end
        end
      end
      ST_TAIL: begin
        if (slot_i) begin
          emit_o      = 1'b1;
          emit_byte_o = tail_byte(idx[2:0]);
          if (idx == TAIL_END) begin
            st_n  = ST_CHK;
            idx_n = '0;
          end else begin
            idx_n = idx + IW'(1);
          end
        end
      end
      ST_BOOT: begin
        if (slot_i) begin
          emit_o      = 1'b1;
          emit_byte_o = BYTE_FILL;
          if (idx == BOOT_END) begin
            st_n  = ST_END;
            idx_n = '0;
          end else begin
            idx_n = idx + IW'(1);
          end
        end
      end
      ST_END: begin
        finish_o = 1'b1;
        st_n     = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      idx    <= '0;
      last_q <= 1'b0;
      ok_o   <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      st  <= st_n;
      idx <= idx_n;
      if (st == ST_IDLE && start_i) begin
        last_q <= 1'b0;
        ok_o   <= 1'b0;
        err_o  <= 1'b0;
      end else begin
        if (take && src_last_i) last_q <= 1'b1;
        if (timeout_o) err_o <= 1'b1;
        if (finish_o) begin
          ok_o  <= last_q && done_hi_i;
          err_o <= !(last_q && done_hi_i);
        end
      end
    end
  end

  assign state_o = st;
endmodule

// File: rtl/cfg_byte_streamer.sv
module cfg_byte_streamer
  import cbs_pkg::*;
#(
  parameter int FRAME_BYTES         = 21,
  parameter int PROG_LOW_CYCLES     = 500,
  parameter int INIT_TIMEOUT_CYCLES = 250000,
  parameter int SPACING             = 4,
  parameter int SYNC_STAGES         = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       src_valid_i,
  input  logic [7:0] src_data_i,
  input  logic       src_last_i,
  output logic       src_ready_o,
  output logic       cfg_wr_o,
  output logic [7:0] cfg_data_o,
  output logic       prog_n_o,
  input  logic       init_n_i,
  input  logic       done_i,
  output logic       busy_o,
  output logic       ok_o,
  output logic       err_o
);
  localparam int TMAX = (PROG_LOW_CYCLES > INIT_TIMEOUT_CYCLES) ? PROG_LOW_CYCLES : INIT_TIMEOUT_CYCLES;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] PROG_LOAD = TW'(PROG_LOW_CYCLES - 1);
  localparam logic [TW-1:0] WAIT_LOAD = TW'(INIT_TIMEOUT_CYCLES - 1);

  logic [1:0]    pins_s;
  logic          init_s, done_s;
  logic          slot_w, emit_w, frame_go_w, timeout_w, finish_w;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic [7:0]    emit_byte;
  cbs_state_e    state_w;

  cbs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({done_i, init_n_i}), .q_o(pins_s)
  );
  assign init_s = pins_s[0];
  assign done_s = pins_s[1];

  cbs_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  cbs_pace #(.SPACING(SPACING)) u_pace (
    .clk(clk), .rst_n(rst_n), .stb_i(emit_w), .slot_o(slot_w)
  );

  cbs_seq #(
    .FRAME_BYTES(FRAME_BYTES), .TW(TW), .PROG_LOAD(PROG_LOAD), .WAIT_LOAD(WAIT_LOAD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .src_valid_i(src_valid_i), .src_data_i(src_data_i), .src_last_i(src_last_i),
    .src_ready_o(src_ready_o), .slot_i(slot_w), .init_hi_i(init_s), .done_hi_i(done_s),
    .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .emit_o(emit_w), .emit_byte_o(emit_byte), .frame_go_o(frame_go_w),
    .timeout_o(timeout_w), .finish_o(finish_w), .state_o(state_w),
    .ok_o(ok_o), .err_o(err_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_wr_o   <= 1'b0;
      cfg_data_o <= 8'hFF;
    end else begin
      cfg_wr_o <= emit_w;
      if (emit_w) cfg_data_o <= emit_byte;
    end
  end

  assign busy_o   = (state_w != ST_IDLE);
  assign prog_n_o = (state_w != ST_PROG);
endmodule

// File: rtl/cbs_checks.sv
module cbs_checks #(
  parameter int SPACING = 4
) (
  input logic clk,
  input logic rst_n,
  input logic prog_n_o,
  input logic cfg_wr_o,
  input logic src_ready_o,
  input logic busy_o,
  input logic ok_o,
  input logic err_o,
  input logic timeout_w,
  input logic frame_go_w
);
  localparam int GW = $clog2(SPACING + 1) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap <= GW'(SPACING);
    else if (cfg_wr_o)              gap <= GW'(1);
    else if (gap < GW'(SPACING))    gap <= gap + GW'(1);
  end

  p_strobe_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_o |-> gap >= GW'(SPACING));

  p_quiet_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> (!cfg_wr_o && !src_ready_o));

  p_write_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_o |-> busy_o);

  p_timeout_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_w |=> (err_o && !busy_o));

  p_preamble_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go_w |=> !src_ready_o);

  p_result_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_o && err_o));

  p_result_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (ok_o || err_o));

  p_ready_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready_o |-> (busy_o && prog_n_o));
endmodule

bind cfg_byte_streamer cbs_checks #(.SPACING(SPACING)) u_cbs_checks (
  .clk(clk), .rst_n(rst_n), .prog_n_o(prog_n_o), .cfg_wr_o(cfg_wr_o),
  .src_ready_o(src_ready_o), .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o),
  .timeout_w(timeout_w), .frame_go_w(frame_go_w)
);

// File: tb/tb_cfg_byte_streamer.sv
module tb_cfg_byte_streamer;
  localparam int CLK_PERIOD = 10;
  localparam int P_LOW      = 20;
  localparam int T_OUT      = 200;
  localparam int GAP        = 2;
  localparam int FB         = 21;
  localparam int INIT_DLY   = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic src_valid = 1'b0;
  logic [7:0] src_data = 8'h00;
  logic src_last = 1'b0;
  logic src_ready, cfg_wr, prog_n, busy, ok, err;
  logic [7:0] cfg_data;
  logic init_pin = 1'b0;
  logic done_pin = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_byte_streamer #(
    .FRAME_BYTES(FB), .PROG_LOW_CYCLES(P_LOW), .INIT_TIMEOUT_CYCLES(T_OUT), .SPACING(GAP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_last_i(src_last),
    .src_ready_o(src_ready), .cfg_wr_o(cfg_wr), .cfg_data_o(cfg_data),
    .prog_n_o(prog_n), .init_n_i(init_pin), .done_i(done_pin),
    .busy_o(busy), .ok_o(ok), .err_o(err)
  );

  logic [7:0] pay [0:127];
  logic [7:0] cap [0:255];
  int n_pay = 0, fidx = 0, ncap = 0, prog_low = 0, min_gap = 1000, since = 1000;
  int early_stb = 0, init_rel = 0, cyc = 0, exp_tot = 0, drop_at = 0;
  bit feed_on = 0, init_auto = 0, init_seen_hi = 0, done_auto = 0, drop_armed = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit cond, input string req, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_at(input int k, input int nfr, input int n);
    int r, f, o, p;
    logic [7:0] hdr [0:7];
    logic [7:0] tl [0:5];
    hdr = '{8'hFF, 8'hFF, 8'hFF, 8'h4F, 8'h80, 8'hAF, 8'h9B, 8'h4B};
    tl  = '{8'h4B, 8'hFF, 8'h4B, 8'hFF, 8'hFF, 8'hFF};
    if (k < 8) return hdr[k];
    r = k - 8;
    if (r >= 28 * nfr) return 8'hFF;
    f = r / 28;
    o = r % 28;
    if (o == 0) return 8'h4F;
    if (o <= FB) begin
      p = f * FB + o - 1;
      return (p < n) ? pay[p] : 8'hFF;
    end
    return tl[o - 22];
  endfunction

  // 0 header, 1 frame payload/framing, 2 pad, 3 startup
  function automatic int seg_of(input int k, input int nfr, input int n);
    int r, o;
    if (k < 8) return 0;
    r = k - 8;
    if (r >= 28 * nfr) return 3;
    o = r % 28;
    if (o >= 1 && o <= FB && ((r / 28) * FB + o - 1) >= n) return 2;
    return 1;
  endfunction

  // Source driver
  initial begin
    forever begin
      @(negedge clk);
      if (feed_on && fidx < n_pay && ($urandom % 4) != 0) begin
        src_valid = 1'b1;
        src_data  = pay[fidx];
        src_last  = (fidx == n_pay - 1);
      end else begin
        src_valid = 1'b0;
        src_last  = 1'b0;
      end
      if (src_valid && src_ready) fidx++;
    end
  end

  // Device model and write monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      since++;
      if (!prog_n) begin
        prog_low++;
        init_pin = 1'b0;
        init_rel = 0;
      end else if (init_auto && !init_pin) begin
        init_rel++;
        if (init_rel >= INIT_DLY) init_pin = 1'b1;
      end
      if (init_pin) init_seen_hi = 1;
      if (cfg_wr) begin
        if (!init_seen_hi) early_stb++;
        if (since < min_gap) min_gap = since;
        since = 0;
        if (ncap < 256) cap[ncap] = cfg_data;
        ncap++;
        if (done_auto && ncap == exp_tot - 2) done_pin = 1'b1;
        if (drop_armed && ncap == drop_at) begin
          init_auto = 0;
          init_pin = 1'b0;
          drop_armed = 0;
        end
      end
    end
  end

  // Watchdog
  initial begin
    wait (cyc >= 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog run did not end actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(output int took);
    int t0;
    t0 = cyc;
    while (busy && (cyc - t0) < 20000) @(negedge clk);
    took = cyc - t0;
    check(!busy, "R7", "busy never dropped", took, 0);
  endtask

  // mode 0 normal, 1 done never high, 2 done high from start, 3 init drops in first frame
  task automatic run(input int n, input int mode);
    int nfr, took, bad_h, bad_f, bad_p, bad_b, lim, exp_take;
    bit exp_ok;
    nfr = (mode == 2) ? 0 : (mode == 3) ? 1 : (n + FB - 1) / FB;
    exp_tot = 8 + 28 * nfr + 4;
    exp_ok = (mode == 0);
    exp_take = (mode == 2) ? 0 : (mode == 3) ? FB : n;
    ncap = 0; prog_low = 0; min_gap = 1000; since = 1000; early_stb = 0;
    init_seen_hi = 0; init_auto = 1; init_pin = 1'b0;
    done_pin = (mode == 2); done_auto = (mode == 0);
    drop_armed = (mode == 3); drop_at = 18;
    fidx = 0; n_pay = n; feed_on = 1;
    pulse_start();
    wait_idle(took);
    feed_on = 0;
    check(prog_low == P_LOW, "R1", "program low cycles", prog_low, P_LOW);
    check(early_stb == 0, "R2", "writes before init high", early_stb, 0);
    check(ncap == exp_tot, "R5", "total writes", ncap, exp_tot);
    bad_h = 0; bad_f = 0; bad_p = 0; bad_b = 0;
    lim = (ncap < exp_tot) ? ncap : exp_tot;
    if (lim > 256) lim = 256;
    for (int k = 0; k < lim; k++) begin
      if (cap[k] !== exp_at(k, nfr, n)) begin
        case (seg_of(k, nfr, n))
          0: bad_h++;
          1: bad_f++;
          2: bad_p++;
          default: bad_b++;
        endcase
      end
    end
    check(bad_h == 0, "R3", "header byte mismatches", bad_h, 0);
    check(bad_f == 0, "R4", "frame byte mismatches", bad_f, 0);
    if (nfr * FB > n) check(bad_p == 0, "R6", "pad byte mismatches", bad_p, 0);
    check(bad_b == 0, "R7", "startup byte mismatches", bad_b, 0);
    check(ok == exp_ok, "R8", "ok flag", ok, exp_ok);
    check(err == !exp_ok, "R8", "err flag", err, !exp_ok);
    if (ncap > 1) check(min_gap >= GAP, "R9", "minimum strobe gap", min_gap, GAP);
    check(fidx == exp_take, "R10", "source bytes taken", fidx, exp_take);
  endtask

  initial begin
    int took, seed, n;
    seed = $urandom(32'h5EED1234);
    repeat (4) @(negedge clk);
    check(prog_n === 1'b1, "R1", "prog_n at reset", prog_n, 1);
    check(busy === 1'b0 && cfg_wr === 1'b0, "R10", "busy/strobe at reset", {busy, cfg_wr}, 0);
    check(ok === 1'b0 && err === 1'b0, "R8", "flags at reset", {ok, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(src_ready === 1'b0, "R10", "ready while idle", src_ready, 0);

    for (int i = 0; i < 128; i++) pay[i] = 8'($urandom);

    run(21, 0);   // exact frame, no pad
    run(22, 0);   // one byte into second frame
    run(1, 0);    // single byte, 20 pad bytes
    run(42, 0);   // two full frames
    for (int r = 0; r < 5; r++) begin
      n = 1 + int'($urandom % 70);
      for (int i = 0; i < 128; i++) pay[i] = 8'($urandom);
      run(n, 0);
    end
    run(30, 1);   // done never rises: error result
    run(30, 2);   // done high at boundary: no frames
    run(50, 3);   // init drops mid first frame: framing stops

    // init never rises: timeout
    ncap = 0; init_auto = 0; init_pin = 1'b0; done_pin = 1'b0; done_auto = 0;
    feed_on = 0; prog_low = 0;
    pulse_start();
    wait_idle(took);
    check(err == 1'b1 && ok == 1'b0, "R2", "timeout flags", {ok, err}, 1);
    check(ncap == 0, "R2", "writes after timeout", ncap, 0);
    check(took + 1 >= P_LOW + T_OUT && took <= P_LOW + T_OUT + 6, "R2", "timeout latency", took, P_LOW + T_OUT);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule